// File: doc/BRIEF.md
# Audio Baud-Rate Clock Generator

This block derives two slow sample-rate clock enables from a set of audio master clocks. It has two divider channels that run independently of each other. Channel A serves the 44.1 kHz family and channel B serves the 48 kHz family. Each channel picks one of four source tick inputs and counts those ticks. It emits a one-cycle enable after every programmed number of ticks. A single flag tells the clock-out pad logic which channel should drive the pad.

Each channel's divide ratio is the product of two terms. The first is a prescaler of 2, 8, 32 or 128. The second is an 8-bit count term from 1 to 256. Ratios from 2 up to 32768 can therefore be set. Software programs the block through a plain write port. Address 0 is the control word. Address 1 is channel A's rate word and address 2 is channel B's rate word. Writes to address 3 are dropped. Each source tick input is a clock enable in the block's clock domain that is high for one cycle per master-clock period.

Top module: `aud_rate_gen`

## Requirements
- R1: A rate word holds the prescaler code n in bits 9:8 and the count term c in bits 7:0. While its source ticks, the channel pulses once every (2·4^n)·(c+1) source ticks.
- R2: Prescaler code 0 gives a prescale of 2, code 1 gives 8, code 2 gives 32 and code 3 gives 128.
- R3: After reset, both rate words hold code 0 with count term 2, which divides by 6. The control word is zero, so both channels use select 0. All three outputs are low.
- R4: Channel A's select sits in control bits 22:20 and channel B's select sits in bits 18:16. Select 0 counts src_tick[0], select 1 counts src_tick[1], select 2 (internal clock) counts src_tick[2] and select 4 counts src_tick[3]. A channel ignores the tick inputs it has not selected.
- R5: The select values 3, 5, 6 and 7 hold that channel's output low no matter what the tick inputs do.
- R6: clkout_sel_b equals control bit 31. It takes the written value in the cycle after the write.
- R7: A rate write arms a reload on its own channel, and a control write arms a reload on both channels. The next selected tick clears both counters and produces no pulse. The first pulse then comes exactly one full new period of ticks after that reload tick.
- R8: Writing one channel's rate word leaves the other channel's period unchanged.
- R9: Each output pulse is high for exactly one cycle, in the cycle after the tick that completes the period. Only ticks advance the counters. Clock cycles without a tick do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 rate A, 2 rate B |
| wr_data | input | 32 | Register write data |
| src_tick | input | 4 | Source clock enables: [0] clock A, [1] clock B, [2] internal, [3] clock C |
| out_a | output | 1 | Channel A divided enable (44.1 kHz family) |
| out_b | output | 1 | Channel B divided enable (48 kHz family) |
| clkout_sel_b | output | 1 | High when channel B should drive the clock-out pad |

## Verification
The select flag is due in the cycle right after its write edge. The bench samples it at the falling edge that closes that write. A divided pulse is due one cycle after the tick that completes a period. A reload takes one tick of its own. The bench therefore expects the first pulse after a rate write at falling edge R+1, counted from the write edge, and it measures steady periods as the gap between two pulses. All stimulus changes on the falling edge and every sample is taken there, so each expected count comes straight from the ratio and the tick spacing.

// File: rtl/aud_rate_pkg.sv
package aud_rate_pkg;

    localparam int PRE_W    = 2;
    localparam int CNT_W    = 8;
    localparam int RATE_W   = PRE_W + CNT_W;
    localparam int SEL_W    = 3;
    localparam int NUM_SRC  = 4;
    localparam int NUM_CH   = 2;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);
    // widest prescaler terminal value is 2*4^(2^PRE_W-1)-1
    localparam int PCNT_W   = 2 * ((1 << PRE_W) - 1) + 1;

    localparam int CTRL_SELA_LSB = 20;
    localparam int CTRL_SELB_LSB = 16;
    localparam int CTRL_OSEL_BIT = 31;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } rate_t;

    typedef struct packed {
        logic             out_b_sel;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
    } ctrl_t;

    typedef struct packed {
        logic                 valid;
        logic [SRC_IDX_W-1:0] idx;
    } src_pick_t;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RATE_A = 2'd1,
        REG_RATE_B = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    localparam rate_t RATE_RST = '{pre: '0, cnt: CNT_W'(2)};
    localparam ctrl_t CTRL_RST = '{out_b_sel: 1'b0, sel_a: '0, sel_b: '0};

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.out_b_sel = w[CTRL_OSEL_BIT];
        c.sel_a     = w[CTRL_SELA_LSB +: SEL_W];
        c.sel_b     = w[CTRL_SELB_LSB +: SEL_W];
        return c;
    endfunction

    function automatic src_pick_t decode_sel(input logic [SEL_W-1:0] s);
        src_pick_t p;
        p = '{valid: 1'b0, idx: '0};
        case (s)
            3'd0: p = '{valid: 1'b1, idx: SRC_IDX_W'(0)};
            3'd1: p = '{valid: 1'b1, idx: SRC_IDX_W'(1)};
            3'd2: p = '{valid: 1'b1, idx: SRC_IDX_W'(2)};
            3'd4: p = '{valid: 1'b1, idx: SRC_IDX_W'(3)};
            default: p = '{valid: 1'b0, idx: '0};
        endcase
        return p;
    endfunction

    function automatic logic [PCNT_W-1:0] pre_last(input logic [PRE_W-1:0] n);
        logic [PCNT_W:0] full;
        full = (PCNT_W+1)'(2) << (2 * n);
        return PCNT_W'(full - 1'b1);
    endfunction

endpackage

// File: rtl/aud_rate_regs.sv
module aud_rate_regs
    import aud_rate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output rate_t             rate_q [NUM_CH],
    output logic [NUM_CH-1:0] reload_q
);

    logic ctrl_hit;
    logic [NUM_CH-1:0] rate_hit;

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(REG_CTRL));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign rate_hit[c] = wr_en && (wr_addr == ADDR_W'(c + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_hit) begin
            ctrl_q <= ctrl_unpack(wr_data[31:0]);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rate
        always_ff @(posedge clk) begin
            if (rst) begin
                rate_q[c]   <= RATE_RST;
                reload_q[c] <= 1'b0;
            end else begin
                reload_q[c] <= rate_hit[c] || ctrl_hit;
                if (rate_hit[c]) begin
                    rate_q[c] <= rate_t'(wr_data[RATE_W-1:0]);
                end
            end
        end
    end

endmodule

// File: rtl/aud_rate_srcmux.sv
module aud_rate_srcmux
    import aud_rate_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    src_pick_t pick;

    always_comb begin
        pick = decode_sel(sel);
        tick = pick.valid && src_tick[pick.idx];
    end

endmodule

// File: rtl/aud_rate_chan.sv
module aud_rate_chan
    import aud_rate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  reload,
    input  rate_t rate,
    output logic  pulse
);

    logic              pend_q;
    logic [PCNT_W-1:0] pre_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pulse_q;
    logic              pre_wrap;
    logic              cnt_last;

    assign pre_wrap = (pre_q == pre_last(rate.pre));
    assign cnt_last = (cnt_q == rate.cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            pre_q   <= '0;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick) begin
                if (pend_q || reload) begin
                    pend_q <= 1'b0;
                    pre_q  <= '0;
                    cnt_q  <= '0;
                end else if (pre_wrap) begin
                    pre_q <= '0;
                    if (cnt_last) begin
                        cnt_q   <= '0;
                        pulse_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end else if (reload) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/aud_rate_gen.sv
module aud_rate_gen
    import aud_rate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic              out_a,
    output logic              out_b,
    output logic              clkout_sel_b
);

    ctrl_t             ctrl_q;
    rate_t             rate_q [NUM_CH];
    logic [NUM_CH-1:0] reload_q;
    logic [NUM_CH-1:0] chan_tick;
    logic [NUM_CH-1:0] chan_pulse;

    aud_rate_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl_q   (ctrl_q),
        .rate_q   (rate_q),
        .reload_q (reload_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        aud_rate_srcmux #(
            .N_SRC (NUM_SRC)
        ) u_mux (
            .src_tick (src_tick),
            .sel      ((g == 0) ? ctrl_q.sel_a : ctrl_q.sel_b),
            .tick     (chan_tick[g])
        );

        aud_rate_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .tick   (chan_tick[g]),
            .reload (reload_q[g]),
            .rate   (rate_q[g]),
            .pulse  (chan_pulse[g])
        );
    end

    assign out_a        = chan_pulse[0];
    assign out_b        = chan_pulse[1];
    assign clkout_sel_b = ctrl_q.out_b_sel;

endmodule

// File: rtl/aud_rate_chk.sv
module aud_rate_chk
    import aud_rate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic [NUM_SRC-1:0] src_tick,
    input logic [SEL_W-1:0]  sel_a,
    input logic              out_a,
    input logic              out_b,
    input logic              clkout_sel_b
);

    AST_PULSE_A_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_a |=> !out_a); // R9
    AST_PULSE_B_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_b |=> !out_b); // R9
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (src_tick == '0) |=> (!out_a && !out_b)); // R9
    AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> (clkout_sel_b == $past(wr_data[31]))); // R6
    AST_UNUSED_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 3'd3 || sel_a == 3'd5 || sel_a == 3'd6 || sel_a == 3'd7) |=> !out_a); // R5
    AST_RELOAD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1) |=> ##1 !out_a); // R7

endmodule

bind aud_rate_gen aud_rate_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .src_tick     (src_tick),
    .sel_a        (ctrl_q.sel_a),
    .out_a        (out_a),
    .out_b        (out_b),
    .clkout_sel_b (clkout_sel_b)
);

// File: tb/aud_rate_gen_bench.sv
module aud_rate_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  src_tick = '0;
    logic        out_a;
    logic        out_b;
    logic        clkout_sel_b;

    logic [3:0]  tick_mask = 4'hF;
    logic        tick_alt = 1'b0;
    logic        phase = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    aud_rate_gen u_aud_rate_gen (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .src_tick     (src_tick),
        .out_a        (out_a),
        .out_b        (out_b),
        .clkout_sel_b (clkout_sel_b)
    );

    always @(negedge clk) begin
        phase    <= ~phase;
        src_tick <= tick_mask & ((tick_alt && phase) ? 4'h0 : 4'hF);
    end

    // {prescaler code, count term, expected period in ticks}
    localparam int NV = 9;
    localparam int VEC [NV][3] = '{
        '{0, 0, 2}, '{0, 2, 6}, '{1, 0, 8}, '{1, 4, 40}, '{2, 1, 64},
        '{3, 0, 128}, '{3, 2, 384}, '{0, 255, 512}, '{2, 7, 256}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic pick(input int ch);
        return (ch == 0) ? out_a : out_b;
    endfunction

    // waits for one pulse, then returns the clock count to the next one
    task automatic measure(input int ch, output int gap, output bit narrow);
        int k;
        gap = -1; narrow = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!pick(ch) && k < 40000);
        if (!pick(ch)) return;
        k = 0;
        do begin
            @(negedge clk); k++;
            if (k == 1 && pick(ch)) narrow = 1'b0;
        end while (!pick(ch) && k < 40000);
        if (pick(ch)) gap = k;
    endtask

    task automatic count_pulses(input int ch, input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pick(ch)) n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int gap, n, k;
        bit narrow;

        repeat (4) @(negedge clk);
        check(!out_a && !out_b && !clkout_sel_b, "R3 reset outputs",
              {out_a, out_b, clkout_sel_b}, 0);
        rst = 1'b0;

        measure(0, gap, narrow);
        check(gap == 6, "R3 default period A", gap, 6);
        measure(1, gap, narrow);
        check(gap == 6, "R3 default period B", gap, 6);

        // table walk: channel A ratios
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, 32'((VEC[i][0] << 8) | VEC[i][1]));
            measure(0, gap, narrow);
            check(gap == VEC[i][2], "R1 R2 period A", gap, VEC[i][2]);
            check(narrow, "R9 pulse width A", 0, 1);
        end

        measure(1, gap, narrow);
        check(gap == 6, "R8 B unchanged by A writes", gap, 6);
        wr(2'd2, 32'h0000_0103);
        measure(1, gap, narrow);
        check(gap == 32, "R1 period B", gap, 32);
        measure(0, gap, narrow);
        check(gap == 256, "R8 A unchanged by B write", gap, 256);

        // reload latency after a rate write
        wr(2'd1, 32'h0000_0004);
        k = 0;
        do begin @(negedge clk); k++; end while (!out_a && k < 1000);
        check(k == 11, "R7 first pulse after rate write", k, 11);
        measure(0, gap, narrow);
        check(gap == 10, "R7 period after reload", gap, 10);

        // control write reloads both channels
        wr(2'd0, 32'h0000_0000);
        k = 0;
        do begin @(negedge clk); k++; end while (!out_a && k < 1000);
        check(k == 11, "R7 first pulse after control write", k, 11);

        // source selection
        tick_mask = 4'b1000;
        wr(2'd0, 32'h0040_0000);
        measure(0, gap, narrow);
        check(gap == 10, "R4 sel 4 uses tick 3", gap, 10);
        count_pulses(1, 100, n);
        check(n == 0, "R4 B ignores unselected ticks", n, 0);
        tick_mask = 4'b0100;
        wr(2'd0, 32'h0020_0000);
        measure(0, gap, narrow);
        check(gap == 10, "R4 sel 2 uses tick 2", gap, 10);
        tick_mask = 4'b0010;
        wr(2'd0, 32'h0010_0000);
        measure(0, gap, narrow);
        check(gap == 10, "R4 sel 1 uses tick 1", gap, 10);
        tick_mask = 4'b1000;
        wr(2'd0, 32'h0004_0000);
        measure(1, gap, narrow);
        check(gap == 32, "R4 B sel 4 uses tick 3", gap, 32);

        // unused encodings
        tick_mask = 4'hF;
        wr(2'd0, 32'h0030_0000);
        count_pulses(0, 200, n);
        check(n == 0, "R5 sel 3 quiet", n, 0);
        wr(2'd0, 32'h0050_0000);
        count_pulses(0, 200, n);
        check(n == 0, "R5 sel 5 quiet", n, 0);
        wr(2'd0, 32'h0070_0000);
        count_pulses(0, 200, n);
        check(n == 0, "R5 sel 7 quiet", n, 0);

        // sparse ticks: only ticks count
        wr(2'd0, 32'h0000_0000);
        tick_alt = 1'b1;
        measure(0, gap, narrow);
        check(gap == 20, "R9 counts ticks not clocks", gap, 20);
        tick_alt = 1'b0;

        // clock-out flag
        wr(2'd0, 32'h8000_0000);
        check(clkout_sel_b == 1'b1, "R6 flag set", clkout_sel_b, 1);
        wr(2'd0, 32'h0000_0000);
        check(clkout_sel_b == 1'b0, "R6 flag clear", clkout_sel_b, 0);

        finish_run();
    end

endmodule